// File: doc/BRIEF.md
# Partitioned Pixel-by-Factor Rounding Multiplier

This block is a SIMD multiply stage for image and signal kernels. One 64-bit operand carries 8-bit pixel components (`pixIn`) and the other carries signed 16-bit scale factors (`facIn`). On each accepted request the block forms up to four independent products. Each product is rounded by a carry into bit 8. The result is either narrowed to a 16-bit lane or kept whole as a 32-bit lane. A 3-bit opcode picks one of seven variants. The variants differ in whether each lane uses its own factor or one factor shared by all lanes, and in which byte of the pixel operand feeds the multiplier and whether that byte is signed.

A request is presented by raising `inValid` for one cycle together with the opcode and both operands. The product appears in the result register on the next clock edge. `outValid` is high for that one cycle. Requests may arrive back to back, one per cycle. Between requests the result register holds its last value.

Lane 0 always occupies the least significant bits of every operand and of the result. A 16-bit lane r sits at bits 16r+15:16r, and a byte r sits at bits 8r+7:8r.

Top module: `pix_scale_top`

## Requirements
- R1: While `rst` is high at a clock edge, the result is cleared to zero and `outValid` goes low on that edge.
- R2: `outValid` is high in exactly the cycles that follow a clock edge at which `inValid` was high, and it is low otherwise.
- R3: After an edge at which `inValid` was low, `result` keeps its previous value.
- R4: Opcode 0 (per-lane). For r = 0..3, the multiplier is byte r of `pixIn`, taken unsigned, and the factor is signed 16-bit lane r of `facIn`. The rounded product, narrowed, goes to 16-bit lane r of the result.
- R5: Rounding. The signed product is taken as a 32-bit two's-complement value. If its low 8 bits exceed 0x7F, 0x100 is added to it. A narrow lane keeps bits 23:8 of that sum. A wide lane keeps all 32 bits of it.
- R6: Opcode 1 follows R4, except that signed 16-bit lane 1 of `facIn` is the factor for all four lanes.
- R7: Opcode 2 follows R4, except that signed 16-bit lane 0 of `facIn` is the factor for all four lanes.
- R8: Opcode 3. The multiplier of lane r is bits 16r+15:16r+8 of `pixIn`, taken as signed. The factor is signed lane r of `facIn`. The result is narrowed.
- R9: Opcode 4. The multiplier of lane r is bits 16r+7:16r of `pixIn` (byte 2r), taken unsigned. The factor is signed lane r of `facIn`. The result is narrowed.
- R10: Opcode 5. Lanes 0 and 1 only, with the sources of R8. The 32-bit rounded value of lane r is written, without a shift, to result bits 32r+31:32r.
- R11: Opcode 6. Lanes 0 and 1 only, with the sources of R9. The 32-bit rounded value is written as in R10.
- R12: Opcode 7 is reserved. It gives an all-zero result and still raises `outValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe; operands and opcode are sampled when it is high |
| opcode | input | 3 | Variant select, 0 to 7 |
| pixIn | input | 64 | Pixel operand (byte sources) |
| facIn | input | 64 | Factor operand (signed 16-bit lanes) |
| result | output | 64 | Registered product lanes |
| outValid | output | 1 | One-cycle strobe marking a new result |

## Verification
The control state is a single registered strobe. A wrong value there shows at the ports in the very next cycle, as a missing, extra or stretched `outValid` pulse, or as a result register that changes while the block is idle. Datapath faults are different: a wrong factor or byte select, a lost sign extension, or a misplaced rounding carry shows only in the lanes whose inputs exercise it. For that reason the stimulus aims at low-byte values just below and just above 0x80, at negative factors and negative pixel bytes, and at factors that differ from lane to lane, so that a broadcast from the wrong lane cannot match by chance. Every such fault appears in the one result word that follows the request.

// File: rtl/pix_scale_pkg.sv
package pix_scale_pkg;

  typedef enum logic [2:0] {
    OP_LANE      = 3'd0,
    OP_BCAST1    = 3'd1,
    OP_BCAST0    = 3'd2,
    OP_HI_S      = 3'd3,
    OP_LO_U      = 3'd4,
    OP_WIDE_HI_S = 3'd5,
    OP_WIDE_LO_U = 3'd6,
    OP_NONE      = 3'd7
  } mulOp_e;

  typedef enum logic [1:0] {
    FAC_OWN   = 2'd0,
    FAC_LANE0 = 2'd1,
    FAC_LANE1 = 2'd2
  } facSel_e;

  typedef enum logic [1:0] {
    SRC_BYTE = 2'd0,
    SRC_HI_S = 2'd1,
    SRC_LO_U = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic    load;
    facSel_e facSel;
    srcSel_e srcSel;
    logic    wide;
    logic    clear;
  } mulStrobe_t;

endpackage

// File: rtl/pix_scale_ctrl.sv
module pix_scale_ctrl
  import pix_scale_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [2:0] opcode,
  output mulStrobe_t strobe,
  output logic       outValid
);

  mulOp_e op;
  assign op = mulOp_e'(opcode);

  always_comb begin
    strobe.load   = inValid;
    strobe.facSel = FAC_OWN;
    strobe.srcSel = SRC_BYTE;
    strobe.wide   = 1'b0;
    strobe.clear  = 1'b0;
    unique case (op)
      OP_LANE:      ;
      OP_BCAST1:    strobe.facSel = FAC_LANE1;
      OP_BCAST0:    strobe.facSel = FAC_LANE0;
      OP_HI_S:      strobe.srcSel = SRC_HI_S;
      OP_LO_U:      strobe.srcSel = SRC_LO_U;
      OP_WIDE_HI_S: begin strobe.srcSel = SRC_HI_S; strobe.wide = 1'b1; end
      OP_WIDE_LO_U: begin strobe.srcSel = SRC_LO_U; strobe.wide = 1'b1; end
      OP_NONE:      strobe.clear = 1'b1;
      default:      strobe.clear = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/pix_scale_lane.sv
module pix_scale_lane #(
  parameter int FAC_W = 16,
  parameter int PIX_W = FAC_W / 2,
  parameter int WIDE_W = 2 * FAC_W
) (
  input  logic signed [FAC_W-1:0]  factor,
  input  logic signed [PIX_W:0]    mulVal,
  output logic        [WIDE_W-1:0] rounded
);

  localparam int PROD_W = FAC_W + PIX_W + 1;

  logic signed [PROD_W-1:0] facExt;
  logic signed [PROD_W-1:0] mulExt;
  logic signed [PROD_W-1:0] prod;
  logic        [WIDE_W-1:0] prodWide;
  logic        [WIDE_W-1:0] roundAdd;

  assign facExt   = $signed({{(PROD_W-FAC_W){factor[FAC_W-1]}}, factor});
  assign mulExt   = $signed({{(PROD_W-PIX_W-1){mulVal[PIX_W]}}, mulVal});
  assign prod     = facExt * mulExt;
  assign prodWide = {{(WIDE_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign roundAdd = {{(WIDE_W-PIX_W-1){1'b0}}, prodWide[PIX_W-1], {PIX_W{1'b0}}};
  assign rounded  = prodWide + roundAdd;

endmodule

// File: rtl/pix_scale_dp.sv
module pix_scale_dp
  import pix_scale_pkg::*;
#(
  parameter int LANES = 4,
  parameter int FAC_W = 16,
  parameter int PIX_W = FAC_W / 2,
  parameter int DATA_W = LANES * FAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  mulStrobe_t        strobe,
  input  logic [DATA_W-1:0] pixIn,
  input  logic [DATA_W-1:0] facIn,
  output logic [DATA_W-1:0] result
);

  localparam int WIDE_W     = 2 * FAC_W;
  localparam int WIDE_LANES = DATA_W / WIDE_W;

  logic [DATA_W-1:0] nextNarrow;
  logic [DATA_W-1:0] nextWide;
  logic [WIDE_W-1:0] laneRounded [LANES];

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    logic signed [FAC_W-1:0] factor;
    logic signed [PIX_W:0]   mulVal;
    logic        [PIX_W-1:0] hiByte;
    logic        [PIX_W-1:0] loByte;
    logic        [PIX_W-1:0] ownByte;

    assign hiByte  = pixIn[r*FAC_W+PIX_W +: PIX_W];
    assign loByte  = pixIn[r*FAC_W +: PIX_W];
    assign ownByte = pixIn[r*PIX_W +: PIX_W];

    always_comb begin
      unique case (strobe.facSel)
        FAC_LANE0: factor = facIn[0 +: FAC_W];
        FAC_LANE1: factor = facIn[FAC_W +: FAC_W];
        default:   factor = facIn[r*FAC_W +: FAC_W];
      endcase
      unique case (strobe.srcSel)
        SRC_HI_S: mulVal = {hiByte[PIX_W-1], hiByte};
        SRC_LO_U: mulVal = {1'b0, loByte};
        default:  mulVal = {1'b0, ownByte};
      endcase
    end

    pix_scale_lane #(.FAC_W(FAC_W), .PIX_W(PIX_W), .WIDE_W(WIDE_W)) u_lane (
      .factor (factor),
      .mulVal (mulVal),
      .rounded(laneRounded[r])
    );

    assign nextNarrow[r*FAC_W +: FAC_W] = laneRounded[r][PIX_W +: FAC_W];
  end

  for (genvar w = 0; w < WIDE_LANES; w++) begin : g_wide
    assign nextWide[w*WIDE_W +: WIDE_W] = laneRounded[w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (strobe.load) begin
      if (strobe.clear)     result <= '0;
      else if (strobe.wide) result <= nextWide;
      else                  result <= nextNarrow;
    end
  end

endmodule

// File: rtl/pix_scale_top.sv
module pix_scale_top
  import pix_scale_pkg::*;
#(
  parameter int LANES = 4,
  parameter int FAC_W = 16,
  parameter int DATA_W = LANES * FAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [2:0]        opcode,
  input  logic [DATA_W-1:0] pixIn,
  input  logic [DATA_W-1:0] facIn,
  output logic [DATA_W-1:0] result,
  output logic              outValid
);

  mulStrobe_t strobe;

  pix_scale_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .opcode  (opcode),
    .strobe  (strobe),
    .outValid(outValid)
  );

  pix_scale_dp #(.LANES(LANES), .FAC_W(FAC_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .pixIn (pixIn),
    .facIn (facIn),
    .result(result)
  );

endmodule

// File: rtl/pix_scale_chk.sv
module pix_scale_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [2:0]        opcode,
  input logic [DATA_W-1:0] pixIn,
  input logic [DATA_W-1:0] facIn,
  input logic [DATA_W-1:0] result,
  input logic              outValid
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && !outValid));

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  p_zero_pix_r9: assert property (@(posedge clk) disable iff (rst)
    (inValid && opcode == 3'd4 && pixIn == '0) |=> result == '0);

  p_zero_fac_r10: assert property (@(posedge clk) disable iff (rst)
    (inValid && opcode == 3'd5 && facIn == '0) |=> result == '0);

  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (inValid && opcode == 3'd7) |=> (result == '0 && outValid));

endmodule

bind pix_scale_top pix_scale_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .opcode  (opcode),
  .pixIn   (pixIn),
  .facIn   (facIn),
  .result  (result),
  .outValid(outValid)
);

// File: tb/sim_pix_scale_top.sv
`timescale 1ns/1ps
module sim_pix_scale_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [2:0]  opcode = 3'd0;
  logic [63:0] pixIn = '0;
  logic [63:0] facIn = '0;
  logic [63:0] result;
  logic        outValid;

  int checks = 0;
  int fails = 0;
  int sent = 0;
  int pulses = 0;
  bit done = 1'b0;
  logic [63:0] lastExp = '0;
  logic [63:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  pix_scale_top u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .opcode(opcode),
    .pixIn(pixIn), .facIn(facIn), .result(result), .outValid(outValid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // rounded 32-bit product per R5
  function automatic logic [31:0] rmul(input logic [15:0] f, input logic [8:0] m);
    logic signed [31:0] p;
    p = $signed({{16{f[15]}}, f}) * $signed({{23{m[8]}}, m});
    if (p[7:0] > 8'h7f) p = p + 32'sh100;
    return p;
  endfunction

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      logic [15:0] f;
      logic [8:0]  m;
      logic [31:0] p;
      f = (op == 3'd1) ? b[31:16] : (op == 3'd2) ? b[15:0] : b[16*i +: 16];
      if (op == 3'd3 || op == 3'd5)      m = {a[16*i+15], a[16*i+8 +: 8]};
      else if (op == 3'd4 || op == 3'd6) m = {1'b0, a[16*i +: 8]};
      else                               m = {1'b0, a[8*i +: 8]};
      p = rmul(f, m);
      if (op == 3'd5 || op == 3'd6) begin
        if (i < 2) r[32*i +: 32] = p;
      end else begin
        r[16*i +: 16] = p[23:8];
      end
    end
    if (op == 3'd7) r = '0;
    return r;
  endfunction

  task automatic send(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b, input string tag);
    @(negedge clk);
    opcode = op; pixIn = a; facIn = b; inValid = 1'b1;
    expQ.push_back(model(op, a, b));
    tagQ.push_back(tag);
    sent++;
  endtask

  task automatic idleCheck(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    inValid = 1'b0; opcode = op; pixIn = a; facIn = b;
    repeat (3) @(negedge clk);
    check("R2 idle valid", {63'd0, outValid}, 64'd0);
    check("R3 hold", result, lastExp);
  endtask

  // monitor: pop and compare whenever a result is flagged
  always @(negedge clk) begin
    if (!rst && outValid) begin
      pulses++;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected valid actual=1 expected=0");
      end else begin
        logic [63:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        lastExp = e;
        check(t, result, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 64'd0);
    check("R1 reset valid", {63'd0, outValid}, 64'd0);
    rst = 1'b0;

    // R5 rounding edges: low byte 0x80, 0x7F, negative factors
    send(3'd0, 64'h0000_0000_0101_0101, 64'h8000_FFFF_007F_0080, "R5 round edges");
    send(3'd0, 64'h0000_0000_FF01_0101, 64'hFF81_0181_0081_00FF, "R5 round near half");
    send(3'd5, 64'h0000_0000_FF00_0100, 64'h0000_0000_0081_FFFF, "R5 wide round");
    send(3'd0, 64'h80FF_7F01_1234_00FF, 64'h7FFF_8000_1234_FFFF, "R4 per-lane");
    send(3'd1, 64'h04030201_0403_0201, 64'h1111_8001_2222_3333, "R6 broadcast lane1");
    send(3'd2, 64'h8040_2010_FF7F_0102, 64'h1111_2222_3333_8181, "R7 broadcast lane0");
    send(3'd3, 64'h80FF_7F00_FF80_0100, 64'h0101_FFFF_1234_7FFF, "R8 upper signed");
    send(3'd4, 64'hFF80_007F_0080_00FF, 64'h0101_FFFF_1234_7FFF, "R9 lower unsigned");
    send(3'd6, 64'h0000_0000_00FF_0080, 64'h0000_0000_8000_7FFF, "R11 wide lower");
    send(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, "R12 reserved");
    idleCheck(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);

    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 6; k++) begin
        logic [63:0] a, b;
        string tg;
        a = {$urandom, $urandom};
        b = {$urandom, $urandom};
        case (op)
          0: tg = "R4 random";
          1: tg = "R6 random";
          2: tg = "R7 random";
          3: tg = "R8 random";
          4: tg = "R9 random";
          5: tg = "R10 random";
          6: tg = "R11 random";
          default: tg = "R12 random";
        endcase
        send(3'(op), a, b, tg);
      end
      idleCheck(3'(op), 64'hA5A5_A5A5_A5A5_A5A5, 64'h5A5A_5A5A_5A5A_5A5A);
    end

    send(3'd5, 64'h8000_7F00_80FF_7F01, 64'hFFFF_0001_8000_7FFF, "R10 wide upper");
    idleCheck(3'd7, '0, '0);
    check("R2 pulse count", 64'(pulses), 64'(sent));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule